// File: doc/BRIEF.md
# Core power-mode reset sequencer

This block sits on the core side of a low-power channel. A power controller asks for a mode by raising a request with a 4-bit target code. One cycle later the block either accepts or refuses. Accept or refusal stays up until the request is withdrawn. From the accepted mode the block drives the core warm reset, a power indication, the enables for the debug port and the functional interfaces, and a cache-invalidate trigger issued after power-on reset. It also drives two sticky preserve flags, one for the L1 data cache and one for the error-record (RAS) state.

Four modes exist:
- **On** is normal operation.
- **Off** powers the core down.
- **Emulated off** keeps the core powered and holds it in warm reset. The debug port stays usable and every functional interface behaves as if the core were off.
- **Debug recovery** is meant for post-mortem debug after a watchdog reset. It is accepted at once from any mode. It keeps the core in warm reset and marks both the cache and the RAS state for preservation.

If the channel already carries the debug recovery code when power-on reset is released, the invalidate pulse is suppressed and the cache is marked as preserved.

The handshake controller has four states:
- BOOT is the single cycle after reset release. It captures the initial mode.
- IDLE waits for a request.
- GRANT holds accept.
- REFUSE holds deny.

Transitions:
- BOOT→IDLE always.
- IDLE→GRANT on a request for a code that is legal from the current mode.
- IDLE→REFUSE on any other request.
- GRANT→IDLE and REFUSE→IDLE when the request drops.

Top module: `core_pwr_seq`

## Requirements
- R1: Target codes on `chan_state` are Off=0x0, emulated off=0x1, debug recovery=0x2, On=0x8. `cur_mode` reports the accepted mode using the same codes.
- R2: A request seen in IDLE raises exactly one of `chan_accept`/`chan_deny` in the cycle after it is sampled. That signal stays high while the request stays high and falls the cycle after the request drops.
- R3: A request for any code other than the four in R1 is refused, and `cur_mode` is left unchanged.
- R4: While in debug recovery, only On, Off or debug recovery are accepted. A request for emulated off is refused.
- R5: A debug recovery request is accepted in one cycle from Off, emulated off and On.
- R6: `cur_mode` changes only on the edge where accept rises, apart from the boot capture.
- R7: `core_warm_rst` is high in every mode except On. `func_port_en` is high only in On.
- R8: In emulated off, `core_pwr_on` and `dbg_port_en` are high, `func_port_en` is low and warm reset is held. In Off, `core_pwr_on` and `dbg_port_en` are low.
- R9: After power-on reset is released with a code other than 0x2 on `chan_state`, `l1_inv` is high for exactly INV_LEN cycles, starting in the cycle after the first edge. The initial mode is the captured code if it is legal, and Off otherwise.
- R10: If `chan_state` is 0x2 at reset release, the following hold:
  - no invalidate pulse is issued;
  - the mode starts as debug recovery;
  - `keep_l1` is set and `keep_ras` stays clear.
- R11: An accepted debug recovery request sets both `keep_l1` and `keep_ras`.
- R12: The preserve flags survive any other transition. They clear only when a handshake that ends in On has completed, that is, when accept falls with the mode On.
- R13: During reset the following hold: mode Off, accept and deny low, warm reset high, all enables low, both flags low, `l1_inv` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous assert |
| chan_req | input | 1 | Power channel request |
| chan_state | input | 4 | Requested mode code, also sampled at reset release |
| chan_accept | output | 1 | Request accepted |
| chan_deny | output | 1 | Request refused |
| cur_mode | output | 4 | Current mode code |
| core_warm_rst | output | 1 | Core warm reset, active high |
| core_pwr_on | output | 1 | Core logic and RAMs powered |
| dbg_port_en | output | 1 | External debug access allowed |
| func_port_en | output | 1 | Functional interfaces active |
| l1_inv | output | 1 | Power-on cache-invalidate pulse |
| keep_l1 | output | 1 | Preserve L1 data cache contents |
| keep_ras | output | 1 | Preserve error-record state |

## Verification
The bench builds the block with INV_LEN=3 rather than the default of 2. A pulse longer than two cycles shows that the pulse length is counted and not produced by a fixed edge detector. The bench counts every cycle `l1_inv` is high after release and compares the count with 3. It also applies power-on reset twice: once with Off on the channel and once with debug recovery. This brings both the normal invalidate path and the suppressed path within reach in one run.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

    localparam int unsigned MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        PM_OFF  = 4'h0,
        PM_EOFF = 4'h1,
        PM_DREC = 4'h2,
        PM_ON   = 4'h8
    } pmode_e;

    typedef enum logic [1:0] {
        HS_BOOT,
        HS_IDLE,
        HS_GRANT,
        HS_REFUSE
    } hs_state_e;

    function automatic logic is_mode_code(input logic [MODE_W-1:0] code);
        return (code == PM_OFF) || (code == PM_EOFF) ||
               (code == PM_DREC) || (code == PM_ON);
    endfunction

endpackage

// File: rtl/cpm_mode_check.sv
module cpm_mode_check
    import cpm_pkg::*;
(
    input  logic [MODE_W-1:0] cur,
    input  logic [MODE_W-1:0] tgt,
    output logic              legal
);

    always_comb begin
        legal = 1'b0;
        unique case (tgt)
            PM_ON, PM_OFF, PM_DREC: legal = 1'b1;
            PM_EOFF:                legal = (cur != PM_DREC);   // R4
            default:                legal = 1'b0;               // R3
        endcase
    end

endmodule

// File: rtl/cpm_hs_fsm.sv
module cpm_hs_fsm
    import cpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic legal,
    output logic take,
    output logic done,
    output logic boot,
    output logic accept,
    output logic deny
);

    hs_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= HS_BOOT;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        take  = 1'b0;
        done  = 1'b0;
        unique case (st)
            HS_BOOT: st_nx = HS_IDLE;
            HS_IDLE: begin
                if (req) begin
                    if (legal) begin
                        st_nx = HS_GRANT;
                        take  = 1'b1;
                    end else begin
                        st_nx = HS_REFUSE;
                    end
                end
            end
            HS_GRANT: begin
                if (!req) begin
                    st_nx = HS_IDLE;
                    done  = 1'b1;
                end
            end
            HS_REFUSE: if (!req) st_nx = HS_IDLE;
            default:   st_nx = HS_IDLE;
        endcase
    end

    always_comb begin
        boot   = (st == HS_BOOT);
        accept = (st == HS_GRANT);
        deny   = (st == HS_REFUSE);
    end

    p_one_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && deny));
    p_accept_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept) |-> $past(req));
    p_accept_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req) |=> accept);
    p_deny_only_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !legal && !boot && !accept && !deny) |=> deny);

endmodule

// File: rtl/cpm_mode_ctrl.sv
module cpm_mode_ctrl
    import cpm_pkg::*;
#(
    parameter int unsigned INV_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot,
    input  logic              take,
    input  logic              done,
    input  logic [MODE_W-1:0] tgt,
    output logic [MODE_W-1:0] mode,
    output logic              warm_rst,
    output logic              pwr_on,
    output logic              dbg_en,
    output logic              func_en,
    output logic              l1_inv,
    output logic              keep_l1,
    output logic              keep_ras
);

    localparam int unsigned CW = $clog2(INV_LEN + 1);

    pmode_e        mode_q;
    logic [CW-1:0] inv_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= PM_OFF;
            inv_cnt  <= '0;
            keep_l1  <= 1'b0;
            keep_ras <= 1'b0;
        end else begin
            if (inv_cnt != '0) inv_cnt <= inv_cnt - 1'b1;
            if (boot) begin
                mode_q <= is_mode_code(tgt) ? pmode_e'(tgt) : PM_OFF;
                if (tgt == PM_DREC) keep_l1 <= 1'b1;          // R10
                else                inv_cnt <= CW'(INV_LEN);  // R9
            end else if (take) begin
                mode_q <= pmode_e'(tgt);
                if (tgt == PM_DREC) begin                     // R11
                    keep_l1  <= 1'b1;
                    keep_ras <= 1'b1;
                end
            end else if (done && mode_q == PM_ON) begin       // R12
                keep_l1  <= 1'b0;
                keep_ras <= 1'b0;
            end
        end
    end

    always_comb begin
        mode     = mode_q;
        warm_rst = 1'b1;
        pwr_on   = 1'b0;
        dbg_en   = 1'b0;
        func_en  = 1'b0;
        unique case (mode_q)
            PM_ON: begin
                warm_rst = 1'b0;
                pwr_on   = 1'b1;
                dbg_en   = 1'b1;
                func_en  = 1'b1;
            end
            PM_EOFF, PM_DREC: begin
                pwr_on = 1'b1;
                dbg_en = 1'b1;
            end
            default: ;
        endcase
        l1_inv = (inv_cnt != '0);
    end

    p_mode_only_on_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !boot) |=> $stable(mode_q));
    p_ras_implies_l1_r11: assert property (@(posedge clk) disable iff (!rst_n)
        keep_ras |-> keep_l1);
    p_no_inv_in_drec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (boot && tgt == PM_DREC) |=> !l1_inv);

endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
    import cpm_pkg::*;
#(
    parameter int unsigned INV_LEN = 2
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        chan_req,
    input  logic [3:0]  chan_state,
    output logic        chan_accept,
    output logic        chan_deny,
    output logic [3:0]  cur_mode,
    output logic        core_warm_rst,
    output logic        core_pwr_on,
    output logic        dbg_port_en,
    output logic        func_port_en,
    output logic        l1_inv,
    output logic        keep_l1,
    output logic        keep_ras
);

    logic legal, take, done, boot;

    cpm_mode_check u_check (
        .cur   (cur_mode),
        .tgt   (chan_state),
        .legal (legal)
    );

    cpm_hs_fsm u_fsm (
        .clk    (clk),
        .rst_n  (por_n),
        .req    (chan_req),
        .legal  (legal),
        .take   (take),
        .done   (done),
        .boot   (boot),
        .accept (chan_accept),
        .deny   (chan_deny)
    );

    cpm_mode_ctrl #(.INV_LEN(INV_LEN)) u_ctrl (
        .clk      (clk),
        .rst_n    (por_n),
        .boot     (boot),
        .take     (take),
        .done     (done),
        .tgt      (chan_state),
        .mode     (cur_mode),
        .warm_rst (core_warm_rst),
        .pwr_on   (core_pwr_on),
        .dbg_en   (dbg_port_en),
        .func_en  (func_port_en),
        .l1_inv   (l1_inv),
        .keep_l1  (keep_l1),
        .keep_ras (keep_ras)
    );

    p_func_not_in_reset_r7: assert property (@(posedge clk) disable iff (!por_n)
        func_port_en |-> !core_warm_rst);
    p_dbg_needs_power_r8: assert property (@(posedge clk) disable iff (!por_n)
        dbg_port_en |-> core_pwr_on);

endmodule

// File: tb/core_pwr_seq_bench.sv
module core_pwr_seq_bench;

    localparam int INV = 3;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       chan_req = 1'b0;
    logic [3:0] chan_state = 4'h0;
    logic       chan_accept, chan_deny;
    logic [3:0] cur_mode;
    logic       core_warm_rst, core_pwr_on, dbg_port_en, func_port_en;
    logic       l1_inv, keep_l1, keep_ras;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    core_pwr_seq #(.INV_LEN(INV)) u_core_pwr_seq (
        .clk(clk), .por_n(por_n), .chan_req(chan_req), .chan_state(chan_state),
        .chan_accept(chan_accept), .chan_deny(chan_deny), .cur_mode(cur_mode),
        .core_warm_rst(core_warm_rst), .core_pwr_on(core_pwr_on),
        .dbg_port_en(dbg_port_en), .func_port_en(func_port_en),
        .l1_inv(l1_inv), .keep_l1(keep_l1), .keep_ras(keep_ras)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_outs(input string tag, input int wr, input int pw,
                            input int dbg, input int fn);
        chk({tag, " warm_rst"}, core_warm_rst, wr);
        chk({tag, " pwr_on"},   core_pwr_on,   pw);
        chk({tag, " dbg_en"},   dbg_port_en,   dbg);
        chk({tag, " func_en"},  func_port_en,  fn);
    endtask

    // handshake: raise req, expect answer one cycle later, held, then released
    task automatic hs(input logic [3:0] code, input bit exp_acc, input string tag);
        @(negedge clk);
        chan_req = 1'b1;
        chan_state = code;
        @(negedge clk);
        chk({tag, " R2 accept"}, chan_accept, exp_acc);
        chk({tag, " R2 deny"},   chan_deny,   !exp_acc);
        @(negedge clk);
        chk({tag, " R2 held"},   chan_accept | chan_deny, 1);
        chan_req = 1'b0;
        @(negedge clk);
        chk({tag, " R2 release"}, chan_accept | chan_deny, 0);
    endtask

    task automatic do_reset(input logic [3:0] init_code, output int pulses);
        @(negedge clk);
        por_n = 1'b0;
        chan_req = 1'b0;
        chan_state = init_code;
        @(negedge clk);
        chk("R13 mode", cur_mode, 0);
        chk("R13 accept/deny", chan_accept | chan_deny, 0);
        chk_outs("R13", 1, 0, 0, 0);
        chk("R13 flags", keep_l1 | keep_ras, 0);
        chk("R13 l1_inv", l1_inv, 0);
        por_n = 1'b1;
        pulses = 0;
        for (int i = 0; i < INV + 3; i++) begin
            @(negedge clk);
            if (l1_inv) pulses++;
        end
    endtask

    task automatic t_por_normal;
        int p;
        do_reset(4'h0, p);
        chk("R9 pulse length", p, INV);
        chk("R9 mode Off", cur_mode, 4'h0);
        chk("R9 flags clear", keep_l1 | keep_ras, 0);
        chk_outs("R8 off", 1, 0, 0, 0);
    endtask

    task automatic t_basic_modes;
        hs(4'h8, 1, "R1 off->on");
        chk("R6 mode on", cur_mode, 4'h8);
        chk_outs("R7 on", 0, 1, 1, 1);
        hs(4'h1, 1, "R1 on->eoff");
        chk("R6 mode eoff", cur_mode, 4'h1);
        chk_outs("R8 eoff", 1, 1, 1, 0);
        hs(4'h0, 1, "R1 eoff->off");
        chk("R6 mode off", cur_mode, 4'h0);
        chk_outs("R8 off", 1, 0, 0, 0);
    endtask

    task automatic t_illegal;
        hs(4'h5, 0, "R3 code5");
        chk("R3 mode unchanged", cur_mode, 4'h0);
        hs(4'hF, 0, "R3 codeF");
        chk("R3 mode unchanged F", cur_mode, 4'h0);
    endtask

    task automatic t_drec_paths;
        hs(4'h2, 1, "R5 off->drec");
        chk("R5 mode", cur_mode, 4'h2);
        chk("R11 keep_l1", keep_l1, 1);
        chk("R11 keep_ras", keep_ras, 1);
        chk_outs("R7 drec", 1, 1, 1, 0);
        hs(4'h1, 0, "R4 drec->eoff");
        chk("R4 mode kept", cur_mode, 4'h2);
        hs(4'h0, 1, "R4 drec->off");
        chk("R12 sticky after off", keep_l1 & keep_ras, 1);
        @(negedge clk);
        chan_req = 1'b1; chan_state = 4'h8;
        @(negedge clk);
        chk("R12 flags during on accept", keep_l1 & keep_ras, 1);
        chan_req = 1'b0;
        @(negedge clk);
        chk("R12 flags cleared", keep_l1 | keep_ras, 0);
        chk("R6 mode on", cur_mode, 4'h8);
        hs(4'h2, 1, "R5 on->drec");
        chk("R5 mode from on", cur_mode, 4'h2);
        hs(4'h8, 1, "R4 drec->on");
        hs(4'h1, 1, "R5 prep eoff");
        hs(4'h2, 1, "R5 eoff->drec");
        chk("R5 mode from eoff", cur_mode, 4'h2);
    endtask

    task automatic t_por_drec;
        int p;
        do_reset(4'h2, p);
        chk("R10 no pulse", p, 0);
        chk("R10 mode", cur_mode, 4'h2);
        chk("R10 keep_l1", keep_l1, 1);
        chk("R10 keep_ras", keep_ras, 0);
        hs(4'h8, 1, "R12 drec->on");
        chk("R12 cleared after on", keep_l1, 0);
    endtask

    initial begin
        t_por_normal();
        t_basic_modes();
        t_illegal();
        t_drec_paths();
        t_por_drec();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule